// File: doc/BRIEF.md
# PS/2 Key-Sequence Wake Detector

This block sits on the clock and data lines of a PS/2 keyboard while the host sleeps. Each frame the device sends is deserialised and checked. A good frame has a start bit of 0, eight data bits with the least significant bit first, odd parity and a stop bit of 1. The received byte is then compared against a bank of eight programmable key bytes. In sequence mode the bytes must arrive in order, from key index 0 up to key index 7. In power-key mode a single byte that equals any programmed key is enough. A match sets a sticky wake flag, which drives the `wake_o` pin.

A second receiver watches a PS/2 mouse and keeps only the low three bits of each good byte. Software uses a small register port to program the keys, the enable bit and the mode bit, to read back the last captured bytes, and to clear the wake flag by writing one to it.

Frame receiver states:
- `RX_IDLE` goes to `RX_DATA` on a falling clock edge that samples a 0 start bit.
- `RX_DATA` goes to `RX_PARITY` after the eighth data edge.
- `RX_PARITY` goes to `RX_STOP` on the parity edge.
- `RX_STOP` goes to `RX_IDLE` on the stop edge.
- Every non-idle state also returns to `RX_IDLE` when the idle timeout expires.

Matcher states:
- `MT_OFF` is the state while matching is disabled.
- `MT_SEQ` is the state in sequence mode.
- `MT_PMK` is the state in power-key mode.
- Each cycle the matcher moves to the state that the enable and mode bits select.

Top module: `ps2_wake_detector`

## Requirements
- R1: While enabled (control bit 0 = 1), each good keyboard frame loads its byte into the keyboard capture register at address 8. This register resets to 00h.
- R2: A keyboard frame with wrong parity (data plus parity bit not odd) or a stop bit of 0 does not change the capture register and is not matched.
- R3: If no PS/2 clock edge arrives for TIMEOUT_CYC system cycles during a frame, the partial frame is dropped. The next frame is then received correctly.
- R4: Key registers 0 to 7 sit at addresses 0 to 7. They are read/write and reset to 00h.
- R5: In sequence mode (control bit 1 = 0), bytes that match key indices 0 through 7 in order set the wake flag on the eighth byte.
- R6: A key register holding 00h accepts any byte at its position in the sequence.
- R7: A byte that fails at the current index resets the match pointer. The same byte is then checked against index 0, so a new attempt can start with it.
- R8: In power-key mode (control bit 1 = 1), a byte equal to any non-zero key register sets the wake flag. A byte that equals no non-zero key does not set it.
- R9: The wake flag (control bit 2, also pin `wake_o`) stays set until a control write with bit 2 = 1 clears it. If a match and such a clear happen in the same cycle, the flag ends up set.
- R10: With control bit 0 = 0, frames neither load the capture registers nor advance or complete a match.
- R11: While enabled, the mouse capture register at address 9 holds bits 2..0 of the last good mouse byte. Bits 7..3 read as zero, and the register resets to 00h.
- R12: The control register at address 10 reads back {00000, wake, mode, enable}. Addresses 11 to 15 read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbd_clk | input | 1 | Keyboard PS/2 clock line |
| kbd_dat | input | 1 | Keyboard PS/2 data line |
| mse_clk | input | 1 | Mouse PS/2 clock line |
| mse_dat | input | 1 | Mouse PS/2 data line |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| wake_o | output | 1 | Sticky wake event |

## Verification
The wake flag has two sources that can meet in one cycle: a match completing on the final stop-bit edge, and a software write-one-to-clear. The bench releases the last falling clock edge of a matching frame. It counts the synchroniser, receiver and flag registers to find the exact cycle in which the match takes effect, and issues the clearing control write in that same cycle. The flag must read as set on the next sample. A separate clearing write afterwards must then drop it.

// File: rtl/ps2w_pkg.sv
package ps2w_pkg;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_DATA   = 2'd1,
        RX_PARITY = 2'd2,
        RX_STOP   = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        MT_OFF = 2'd0,
        MT_SEQ = 2'd1,
        MT_PMK = 2'd2
    } match_state_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_PM_BIT   = 1;
    localparam int CTRL_WAKE_BIT = 2;

endpackage

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2w_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000,
    parameter int DW          = 8,
    localparam int TW         = $clog2(TIMEOUT_CYC + 1),
    localparam int CW         = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_clk,
    input  logic          line_dat,
    output logic          frame_ok,
    output logic [DW-1:0] frame_byte
);

    logic [2:0]    clk_sync;
    logic [1:0]    dat_sync;
    logic          fall;
    logic          sbit;
    rx_state_e     state, state_nx;
    logic [TW-1:0] gap_cnt;
    logic          gap_expired;
    logic [DW-1:0] shreg;
    logic [CW-1:0] bit_idx;
    logic          par_bit;
    logic          last_bit;

    // line synchronisers, idle level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sync <= '1;
            dat_sync <= '1;
        end else begin
            clk_sync <= {clk_sync[1:0], line_clk};
            dat_sync <= {dat_sync[0], line_dat};
        end
    end

    assign fall        = clk_sync[2] & ~clk_sync[1];
    assign sbit        = dat_sync[1];
    assign last_bit    = (bit_idx == CW'(DW - 1));
    assign gap_expired = (gap_cnt == TW'(TIMEOUT_CYC - 1)) && !fall;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (fall && !sbit) state_nx = RX_DATA;
            RX_DATA:   if (gap_expired) state_nx = RX_IDLE;
                       else if (fall && last_bit) state_nx = RX_PARITY;
            RX_PARITY: if (gap_expired) state_nx = RX_IDLE;
                       else if (fall) state_nx = RX_STOP;
            RX_STOP:   if (gap_expired || fall) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // inter-edge gap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          gap_cnt <= '0;
        else if (state == RX_IDLE || fall)   gap_cnt <= '0;
        else                                 gap_cnt <= gap_cnt + TW'(1);
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_idx    <= '0;
            par_bit    <= 1'b0;
            frame_ok   <= 1'b0;
            frame_byte <= '0;
        end else begin
            frame_ok <= 1'b0;
            unique case (state)
                RX_IDLE: bit_idx <= '0;
                RX_DATA: if (fall) begin
                    shreg   <= {sbit, shreg[DW-1:1]};
                    bit_idx <= bit_idx + CW'(1);
                end
                RX_PARITY: if (fall) par_bit <= sbit;
                RX_STOP: if (fall && sbit && (^{shreg, par_bit})) begin
                    frame_ok   <= 1'b1;
                    frame_byte <= shreg;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/key_seq_matcher.sv
module key_seq_matcher
    import ps2w_pkg::*;
#(
    parameter int NKEYS = 8,
    localparam int PW   = $clog2(NKEYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  pm_mode,
    input  logic                  byte_ok,
    input  logic [7:0]            byte_in,
    input  logic [NKEYS-1:0][7:0] keys,
    output logic                  hit,
    output logic [PW-1:0]         ptr
);

    localparam logic [PW-1:0] LAST = PW'(NKEYS - 1);

    match_state_e     state, state_nx;
    logic [NKEYS-1:0] pos_ok;
    logic [NKEYS-1:0] pm_hit;
    logic             live;
    logic [PW-1:0]    ptr_nx;

    for (genvar g = 0; g < NKEYS; g++) begin : g_cmp
        assign pos_ok[g] = (keys[g] == 8'h00) || (keys[g] == byte_in);
        assign pm_hit[g] = (keys[g] != 8'h00) && (keys[g] == byte_in);
    end

    assign live = byte_ok && enable;

    always_comb begin
        if (!enable)      state_nx = MT_OFF;
        else if (pm_mode) state_nx = MT_PMK;
        else              state_nx = MT_SEQ;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MT_OFF;
        else        state <= state_nx;
    end

    // outputs and pointer update
    always_comb begin
        hit    = 1'b0;
        ptr_nx = ptr;
        unique case (state)
            MT_OFF: ptr_nx = '0;
            MT_SEQ: if (live) begin
                if (pos_ok[ptr]) begin
                    if (ptr == LAST) begin
                        hit    = !pm_mode;
                        ptr_nx = '0;
                    end else begin
                        ptr_nx = ptr + PW'(1);
                    end
                end else begin
                    ptr_nx = pos_ok[0] ? PW'(1) : PW'(0);
                end
            end
            MT_PMK: begin
                ptr_nx = '0;
                hit    = live && pm_mode && (|pm_hit);
            end
            default: ptr_nx = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ptr <= '0;
        else if (!enable || pm_mode) ptr <= '0;
        else                         ptr <= ptr_nx;
    end

endmodule

// File: rtl/ps2w_regs.sv
module ps2w_regs
    import ps2w_pkg::*;
#(
    parameter int NKEYS    = 8,
    parameter int MSE_BITS = 3,
    localparam int AW      = $clog2(NKEYS + 3),
    localparam int A_KCAP  = NKEYS,
    localparam int A_MCAP  = NKEYS + 1,
    localparam int A_CTRL  = NKEYS + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic                  wr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic                  kbd_ok,
    input  logic [7:0]            kbd_byte,
    input  logic                  mse_ok,
    input  logic [7:0]            mse_byte,
    input  logic                  hit,
    output logic [NKEYS-1:0][7:0] keys,
    output logic [7:0]            kbd_cap,
    output logic                  enable,
    output logic                  pm_mode,
    output logic                  wake
);

    logic [MSE_BITS-1:0] mse_cap;
    logic                ctrl_wr;

    assign ctrl_wr = wr && (addr == AW'(A_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keys <= '0;
        end else begin
            for (int i = 0; i < NKEYS; i++) begin
                if (wr && addr == AW'(i)) keys[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable  <= 1'b0;
            pm_mode <= 1'b0;
        end else if (ctrl_wr) begin
            enable  <= wdata[CTRL_EN_BIT];
            pm_mode <= wdata[CTRL_PM_BIT];
        end
    end

    // set beats clear when both land in one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              wake <= 1'b0;
        else if (hit)                            wake <= 1'b1;
        else if (ctrl_wr && wdata[CTRL_WAKE_BIT]) wake <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kbd_cap <= '0;
            mse_cap <= '0;
        end else begin
            if (kbd_ok && enable) kbd_cap <= kbd_byte;
            if (mse_ok && enable) mse_cap <= mse_byte[MSE_BITS-1:0];
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NKEYS; i++) begin
            if (addr == AW'(i)) rdata = keys[i];
        end
        if (addr == AW'(A_KCAP)) rdata = kbd_cap;
        if (addr == AW'(A_MCAP)) rdata[MSE_BITS-1:0] = mse_cap;
        if (addr == AW'(A_CTRL)) begin
            rdata[CTRL_EN_BIT]   = enable;
            rdata[CTRL_PM_BIT]   = pm_mode;
            rdata[CTRL_WAKE_BIT] = wake;
        end
    end

endmodule

// File: rtl/ps2_wake_detector.sv
module ps2_wake_detector
    import ps2w_pkg::*;
#(
    parameter int NKEYS       = 8,
    parameter int TIMEOUT_CYC = 100000,
    parameter int MSE_BITS    = 3,
    localparam int AW         = $clog2(NKEYS + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kbd_clk,
    input  logic          kbd_dat,
    input  logic          mse_clk,
    input  logic          mse_dat,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          wake_o
);

    localparam int PW = $clog2(NKEYS);

    logic                  kbd_ok, mse_ok;
    logic [7:0]            kbd_byte, mse_byte;
    logic [7:0]            kbd_cap;
    logic [NKEYS-1:0][7:0] keys;
    logic                  ctrl_en, ctrl_pm;
    logic                  seq_hit;
    logic [PW-1:0]         match_ptr;

    ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC), .DW(8)) u_kbd_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_clk   (kbd_clk),
        .line_dat   (kbd_dat),
        .frame_ok   (kbd_ok),
        .frame_byte (kbd_byte)
    );

    ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC), .DW(8)) u_mse_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_clk   (mse_clk),
        .line_dat   (mse_dat),
        .frame_ok   (mse_ok),
        .frame_byte (mse_byte)
    );

    key_seq_matcher #(.NKEYS(NKEYS)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_en),
        .pm_mode (ctrl_pm),
        .byte_ok (kbd_ok),
        .byte_in (kbd_byte),
        .keys    (keys),
        .hit     (seq_hit),
        .ptr     (match_ptr)
    );

    ps2w_regs #(.NKEYS(NKEYS), .MSE_BITS(MSE_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .kbd_ok   (kbd_ok),
        .kbd_byte (kbd_byte),
        .mse_ok   (mse_ok),
        .mse_byte (mse_byte),
        .hit      (seq_hit),
        .keys     (keys),
        .kbd_cap  (kbd_cap),
        .enable   (ctrl_en),
        .pm_mode  (ctrl_pm),
        .wake     (wake_o)
    );

endmodule

// File: rtl/ps2_wake_checker.sv
module ps2_wake_checker #(
    parameter int AW        = 4,
    parameter int PW        = 3,
    parameter int CTRL_ADDR = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic [7:0]    reg_wdata,
    input logic          wake_o,
    input logic          kbd_ok,
    input logic [7:0]    kbd_cap,
    input logic          hit,
    input logic          enable,
    input logic          pm_mode,
    input logic [PW-1:0] ptr
);

    logic clr_req;
    assign clr_req = reg_wr && (reg_addr == AW'(CTRL_ADDR)) && reg_wdata[2];

    p_hit_sets_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> wake_o);

    p_wake_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !clr_req) |=> wake_o);

    p_wake_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(hit));

    p_no_hit_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !hit);

    p_cap_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_ok |=> $stable(kbd_cap));

    p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_ok |=> !kbd_ok);

    p_ptr_idle_pmk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode |=> (ptr == '0));

endmodule

bind ps2_wake_detector ps2_wake_checker #(
    .AW(AW), .PW(PW), .CTRL_ADDR(NKEYS + 2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .wake_o    (wake_o),
    .kbd_ok    (kbd_ok),
    .kbd_cap   (kbd_cap),
    .hit       (seq_hit),
    .enable    (ctrl_en),
    .pm_mode   (ctrl_pm),
    .ptr       (match_ptr)
);

// File: tb/ps2_wake_detector_test.sv
module ps2_wake_detector_test;

    localparam int TMO  = 1000;
    localparam int HALF = 20;
    localparam int NV   = 21;

    // entry = {byte, expected wake after frame, clear afterwards}
    localparam logic [9:0] VEC [NV] = '{
        {8'h12, 1'b0, 1'b0}, {8'h1C, 1'b0, 1'b0}, {8'hAB, 1'b0, 1'b0},
        {8'h33, 1'b0, 1'b0}, {8'h44, 1'b0, 1'b0}, {8'h55, 1'b0, 1'b0},
        {8'h66, 1'b0, 1'b0}, {8'h77, 1'b0, 1'b0}, {8'h88, 1'b1, 1'b1},
        {8'h1C, 1'b0, 1'b0}, {8'hAB, 1'b0, 1'b0}, {8'h33, 1'b0, 1'b0},
        {8'h1C, 1'b0, 1'b0}, {8'hAB, 1'b0, 1'b0}, {8'h33, 1'b0, 1'b0},
        {8'h44, 1'b0, 1'b0}, {8'h55, 1'b0, 1'b0}, {8'h66, 1'b0, 1'b0},
        {8'h77, 1'b0, 1'b0}, {8'h88, 1'b1, 1'b1}, {8'h5E, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kc = 1'b1, kd = 1'b1, mc = 1'b1, md = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wake_o;
    int         checks = 0;
    int         fails  = 0;

    always #10 clk = ~clk;

    ps2_wake_detector #(.NKEYS(8), .TIMEOUT_CYC(TMO), .MSE_BITS(3)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_clk   (kc),
        .kbd_dat   (kd),
        .mse_clk   (mc),
        .mse_dat   (md),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wake_o    (wake_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic send(input logic mouse, input logic [7:0] b, input logic bad_par,
                        input logic bad_stop, input int nbits, input logic collide);
        logic [10:0] fr;
        fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (mouse) md = fr[i]; else kd = fr[i];
            repeat (HALF) @(negedge clk);
            if (mouse) mc = 1'b0; else kc = 1'b0;
            if (collide && i == 10) begin
                repeat (3) @(negedge clk);
                reg_addr = 4'd10; reg_wdata = 8'h07; reg_wr = 1'b1;
                @(negedge clk);
                reg_wr = 1'b0;
                chk("R9 match and clear in one cycle", {7'b0, wake_o}, 8'h01);
                repeat (HALF - 4) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            if (mouse) mc = 1'b1; else kc = 1'b1;
        end
    endtask

    task automatic kbyte(input logic [7:0] b);
        send(1'b0, b, 1'b0, 1'b0, 11, 1'b0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        for (int i = 0; i < 8; i++) rd_chk("R4 key reset", 4'(i), 8'h00);
        rd_chk("R1 capture reset", 4'd8, 8'h00);
        rd_chk("R11 mouse reset", 4'd9, 8'h00);
        rd_chk("R12 ctrl reset", 4'd10, 8'h00);
        chk("R9 wake reset", {7'b0, wake_o}, 8'h00);

        // program keys, index 1 is don't-care
        wr(4'd0, 8'h1C); wr(4'd1, 8'h00); wr(4'd2, 8'h33); wr(4'd3, 8'h44);
        wr(4'd4, 8'h55); wr(4'd5, 8'h66); wr(4'd6, 8'h77); wr(4'd7, 8'h88);
        rd_chk("R4 key readback", 4'd2, 8'h33);
        rd_chk("R4 key readback", 4'd7, 8'h88);
        wr(4'd10, 8'h01);
        rd_chk("R12 ctrl enable", 4'd10, 8'h01);

        // sequence table: R5 order, R6 don't-care, R7 restart on mismatch
        for (int v = 0; v < NV; v++) begin
            kbyte(VEC[v][9:2]);
            chk("R5/R6/R7 sequence wake", {7'b0, wake_o}, {7'b0, VEC[v][1]});
            rd_chk("R1 capture", 4'd8, VEC[v][9:2]);
            if (VEC[v][0]) begin
                wr(4'd10, 8'h05);
                chk("R9 clear", {7'b0, wake_o}, 8'h00);
            end
        end

        // R2: bad parity and bad stop discarded
        send(1'b0, 8'h5A, 1'b1, 1'b0, 11, 1'b0);
        rd_chk("R2 bad parity", 4'd8, 8'h5E);
        send(1'b0, 8'h5B, 1'b0, 1'b1, 11, 1'b0);
        rd_chk("R2 bad stop", 4'd8, 8'h5E);
        kbyte(8'h5C);
        rd_chk("R1 good after bad", 4'd8, 8'h5C);

        // R3: partial frame then idle timeout
        send(1'b0, 8'hFF, 1'b0, 1'b0, 4, 1'b0);
        repeat (TMO + 50) @(negedge clk);
        kbyte(8'h3E);
        rd_chk("R3 timeout recovery", 4'd8, 8'h3E);

        // R10: disabled
        wr(4'd10, 8'h00);
        kbyte(8'h1C); kbyte(8'hAB); kbyte(8'h33); kbyte(8'h44);
        kbyte(8'h55); kbyte(8'h66); kbyte(8'h77); kbyte(8'h88);
        chk("R10 no wake when disabled", {7'b0, wake_o}, 8'h00);
        rd_chk("R10 no capture when disabled", 4'd8, 8'h3E);
        send(1'b1, 8'hFD, 1'b0, 1'b0, 11, 1'b0);
        rd_chk("R10 no mouse capture when disabled", 4'd9, 8'h00);
        wr(4'd10, 8'h01);
        kbyte(8'h44);
        rd_chk("R1 capture after re-enable", 4'd8, 8'h44);

        // R8: power-key mode
        wr(4'd10, 8'h03);
        rd_chk("R12 ctrl mode", 4'd10, 8'h03);
        kbyte(8'h12);
        chk("R8 non-key byte", {7'b0, wake_o}, 8'h00);
        kbyte(8'h00);
        chk("R8 zero key never matches", {7'b0, wake_o}, 8'h00);
        kbyte(8'h55);
        chk("R8 key match", {7'b0, wake_o}, 8'h01);
        rd_chk("R12 ctrl wake bit", 4'd10, 8'h07);
        kbyte(8'h12);
        chk("R9 sticky", {7'b0, wake_o}, 8'h01);
        wr(4'd10, 8'h07);
        chk("R9 clear", {7'b0, wake_o}, 8'h00);

        // R9: collision of match and clear
        send(1'b0, 8'h66, 1'b0, 1'b0, 11, 1'b1);
        chk("R9 set held after collision", {7'b0, wake_o}, 8'h01);
        wr(4'd10, 8'h07);
        chk("R9 clear after collision", {7'b0, wake_o}, 8'h00);

        // R11: mouse capture
        send(1'b1, 8'hFD, 1'b0, 1'b0, 11, 1'b0);
        rd_chk("R11 mouse low bits", 4'd9, 8'h05);
        send(1'b1, 8'h32, 1'b0, 1'b0, 11, 1'b0);
        rd_chk("R11 mouse low bits", 4'd9, 8'h02);

        // R12: unmapped addresses
        for (int a = 11; a < 16; a++) rd_chk("R12 unmapped", 4'(a), 8'h00);

        finish_run();
    end

endmodule